// File: doc/BRIEF.md
# Configurable UART Frame Transmitter

This block turns bytes held in a small transmit buffer into asynchronous serial frames on a single output line. A byte is written with a one-cycle strobe and waits in the buffer until the serializer is free, transmission is enabled and, when hardware flow control is on, the far end is asserting clear-to-send. The frame shape is set by static configuration inputs: 5 to 8 data bits, one or two stop bits, and an optional parity bit that can be odd, even, or held at a constant mark or space level.

Bit timing comes from a programmable divider. The divider produces a tick, and each bit on the line lasts sixteen ticks. A break control pulls the line low for as long as it is held. A loopback control moves the outgoing waveform from the line pin to a separate loopback output and parks the line pin at the idle level. A flush control drops every byte still in the buffer. An empty indication reports when there is nothing left to send and the line has gone idle.

Top module: `uart_frame_tx`

## Requirements
- R1: The divisor input holds the divide value minus one, so 0 gives a tick on every clock and N gives one tick every N+1 clocks. Each bit on the line lasts 16 ticks. The divider counts from reset, and the tick fires when its count reaches the divisor.
- R2: A frame is one low start bit, then the data bits least significant first, then the parity bit if enabled, then the stop bits driven high. The start bit appears on the line in the cycle after the frame is taken from the buffer.
- R3: The 2-bit length code selects 5 (code 0), 6 (code 1), 7 (code 2) or 8 (code 3) data bits. Byte bits above the selected length are not sent.
- R4: When the stop control is 1 the frame ends with two stop bits, and when it is 0 it ends with one.
- R5: With parity enabled and stick clear, the parity bit makes the count of ones in data plus parity even when the even-select input is 1, and odd when it is 0. With stick set, the parity bit is 1 when even-select is 0 and 0 when even-select is 1.
- R6: While break is 1 the transmitted waveform is held low. The serializer keeps its timing while break is held.
- R7: With CTS flow control enabled, a new frame starts only in a cycle where cts is 1. A frame already started always runs to its last stop bit.
- R8: A new frame starts only while the transmit enable is 1. A frame in progress completes after the enable is cleared.
- R9: A flush pulse empties the buffer by the next cycle, and a write in the same cycle is dropped. No frame starts in a flush cycle. A frame already on the line completes.
- R10: The buffer holds DEPTH bytes (4 by default) in first-in first-out order. A write to a full buffer is ignored. The buffer count output reports the number of stored bytes.
- R11: The empty output is 1 only when the buffer is empty and the line is idle.
- R12: With loopback set, the line output stays at 1 and the loopback output carries the waveform. With loopback clear, the loopback output stays at 1.
- R13: The line is high when idle and out of reset. The frame format is captured when a frame starts, so configuration changes made during a frame do not affect that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Single-cycle byte write strobe |
| wr_data | input | 8 | Byte to enqueue |
| tx_enable | input | 1 | Allows new frames to start |
| flush | input | 1 | Discards all buffered bytes |
| div_m1 | input | DIV_W | Divide value minus one for the tick divider |
| len_code | input | 2 | Data length code, 0..3 for 5..8 bits |
| two_stop | input | 1 | 1 selects two stop bits |
| par_en | input | 1 | Parity bit enable |
| par_even | input | 1 | Even parity select, or space level under stick |
| par_stick | input | 1 | Forces the parity bit to a constant |
| brk | input | 1 | Holds the transmitted waveform low |
| loop_en | input | 1 | Routes the waveform to loop_txd and parks txd high |
| cts_flow | input | 1 | Enables gating of frame starts by cts |
| cts | input | 1 | Clear-to-send from the far end, active high |
| txd | output | 1 | Serial line output |
| loop_txd | output | 1 | Loopback copy of the waveform |
| buf_count | output | $clog2(DEPTH+1) | Number of bytes held in the buffer |
| tx_empty | output | 1 | Buffer empty and serializer idle |

## Verification
The bench writes past the buffer's capacity while sending is disabled. A design that wrapped its pointers on overflow would corrupt the queue order, and one that stalled would never drain. It drops cts in the middle of a frame. A design that aborted the frame would cut the stop bits short, and one that ignored cts would start the next byte early. It pulses flush together with a write while a frame is on the line. A design that let the write through or cut the frame off would show a wrong count or a shortened waveform. Every parity mode, every length code, the two-stop setting and a divisor above zero are run, along with a configuration change during a frame. A wrong mask, a wrong parity sense or an off-by-one in the tick divider would shift or flip bits against the cycle-accurate model.

// File: rtl/utx_pkg.sv
package utx_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_SEND = 1'b1
  } tx_state_e;

  localparam int FRAME_W    = 12;
  localparam int TICKS_PER_BIT = 16;

  function automatic logic calc_parity(input logic [7:0] d,
                                       input logic [1:0] len,
                                       input logic       even,
                                       input logic       stick);
    logic [7:0] msk;
    msk = 8'hFF >> (2'd3 - len);
    if (stick) return ~even;
    return even ? (^(d & msk)) : (~^(d & msk));
  endfunction

endpackage

// File: rtl/utx_baud_gen.sv
module utx_baud_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_m1,
  output logic             tick
);

  logic [DIV_W-1:0] cnt_q, cnt_d;

  always_comb begin
    tick  = (cnt_q >= div_m1);
    cnt_d = tick ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R1: with a nonzero divisor a tick is never followed directly by another
  p_tick_gap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div_m1 != '0 && $stable(div_m1)) |=> (!tick || div_m1 == '0));

endmodule

// File: rtl/utx_fifo.sv
module utx_fifo #(
  parameter int DEPTH = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         flush,
  input  logic                         push_req,
  input  logic [7:0]                   wr_data,
  input  logic                         pop,
  output logic [7:0]                   rd_data,
  output logic [$clog2(DEPTH+1)-1:0]   count,
  output logic                         empty
);

  localparam int CW = $clog2(DEPTH + 1);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          do_push, do_pop;

  always_comb begin
    do_push = push_req && (cnt_q != CW'(DEPTH)) && !flush;
    do_pop  = pop && (cnt_q != '0) && !flush;
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (flush) begin
      wp_d  = '0;
      rp_d  = '0;
      cnt_d = '0;
    end else begin
      if (do_push) wp_d = (wp_q == LAST) ? '0 : wp_q + 1'b1;
      if (do_pop)  rp_d = (rp_q == LAST) ? '0 : rp_q + 1'b1;
      cnt_d = cnt_q + CW'(do_push) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp_q] <= wr_data;
  end

  assign rd_data = mem[rp_q];
  assign count   = cnt_q;
  assign empty   = (cnt_q == '0);

  p_count_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));

  p_full_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CW'(DEPTH) && push_req && !pop && !flush) |=> (cnt_q == CW'(DEPTH)));

  p_flush_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (cnt_q == '0));

endmodule

// File: rtl/utx_shifter.sv
module utx_shifter
  import utx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       can_start,
  input  logic [7:0] data,
  input  logic [1:0] len_code,
  input  logic       two_stop,
  input  logic       par_en,
  input  logic       par_even,
  input  logic       par_stick,
  output logic       start,
  output logic       busy,
  output logic       line
);

  localparam int LW = $clog2(FRAME_W + 1);

  tx_state_e          state_q, state_d;
  logic [FRAME_W-1:0] frame_q, frame_d, load_frame;
  logic [LW-1:0]      left_q, left_d, load_len;
  logic [3:0]         sub_q, sub_d;
  logic [3:0]         n_data;
  logic               pbit;

  // frame image built from the head byte and the current configuration
  always_comb begin
    n_data     = 4'd5 + {2'b00, len_code};
    pbit       = calc_parity(data, len_code, par_even, par_stick);
    load_frame = '1;
    load_frame[0] = 1'b0;
    for (int i = 0; i < 8; i++) begin
      if (4'(i) < n_data) load_frame[1+i] = data[i];
    end
    if (par_en) load_frame[4'd1 + n_data] = pbit;
    load_len = LW'(n_data) + LW'(2) + LW'(par_en) + LW'(two_stop);
  end

  always_comb begin
    state_d = state_q;
    frame_d = frame_q;
    left_d  = left_q;
    sub_d   = sub_q;
    start   = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (can_start) begin
          start   = 1'b1;
          state_d = ST_SEND;
          frame_d = load_frame;
          left_d  = load_len;
          sub_d   = '0;
        end
      end
      ST_SEND: begin
        if (tick) begin
          if (sub_q == 4'(TICKS_PER_BIT - 1)) begin
            sub_d   = '0;
            frame_d = {1'b1, frame_q[FRAME_W-1:1]};
            left_d  = left_q - 1'b1;
            if (left_q == LW'(1)) state_d = ST_IDLE;
          end else begin
            sub_d = sub_q + 1'b1;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      frame_q <= '1;
      left_q  <= '0;
      sub_q   <= '0;
    end else begin
      state_q <= state_d;
      frame_q <= frame_d;
      left_q  <= left_d;
      sub_q   <= sub_d;
    end
  end

  assign busy = (state_q == ST_SEND);
  assign line = busy ? frame_q[0] : 1'b1;

  p_start_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && can_start) |=> (busy && !line));

  p_idle_high_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> line);

  p_bit_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tick) |=> (busy && $stable(line)));

endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx #(
  parameter int DEPTH = 4,
  parameter int DIV_W = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [7:0]                 wr_data,
  input  logic                       tx_enable,
  input  logic                       flush,
  input  logic [DIV_W-1:0]           div_m1,
  input  logic [1:0]                 len_code,
  input  logic                       two_stop,
  input  logic                       par_en,
  input  logic                       par_even,
  input  logic                       par_stick,
  input  logic                       brk,
  input  logic                       loop_en,
  input  logic                       cts_flow,
  input  logic                       cts,
  output logic                       txd,
  output logic                       loop_txd,
  output logic [$clog2(DEPTH+1)-1:0] buf_count,
  output logic                       tx_empty
);

  logic       tick, fifo_empty, can_start, start, busy, line, tx_raw;
  logic [7:0] head;

  utx_baud_gen #(.DIV_W(DIV_W)) u_baud (
    .clk    (clk),
    .rst_n  (rst_n),
    .div_m1 (div_m1),
    .tick   (tick)
  );

  utx_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (flush),
    .push_req (wr_en),
    .wr_data  (wr_data),
    .pop      (start),
    .rd_data  (head),
    .count    (buf_count),
    .empty    (fifo_empty)
  );

  assign can_start = !fifo_empty && tx_enable && (!cts_flow || cts) && !flush;

  utx_shifter u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .can_start (can_start),
    .data      (head),
    .len_code  (len_code),
    .two_stop  (two_stop),
    .par_en    (par_en),
    .par_even  (par_even),
    .par_stick (par_stick),
    .start     (start),
    .busy      (busy),
    .line      (line)
  );

  assign tx_raw   = brk ? 1'b0 : line;
  assign txd      = loop_en ? 1'b1 : tx_raw;
  assign loop_txd = loop_en ? tx_raw : 1'b1;
  assign tx_empty = fifo_empty && !busy;

  p_cts_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cts_flow && !cts) |=> !busy);

  p_enable_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !tx_enable) |=> !busy);

  p_empty_r11: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty |-> (buf_count == '0));

  p_break_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (brk && !loop_en) |-> !txd);

endmodule

// File: tb/uart_frame_tx_tb.sv
`timescale 1ns/1ps
module uart_frame_tx_tb;

  localparam int DEPTH = 4;
  localparam int DIV_W = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic wr_en, tx_enable, flush, two_stop, par_en, par_even, par_stick;
  logic brk, loop_en, cts_flow, cts;
  logic [7:0] wr_data;
  logic [DIV_W-1:0] div_m1;
  logic [1:0] len_code;
  logic txd, loop_txd, tx_empty;
  logic [2:0] buf_count;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  string tag = "R13";

  always #4 clk = ~clk;

  uart_frame_tx #(.DEPTH(DEPTH), .DIV_W(DIV_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .tx_enable(tx_enable), .flush(flush), .div_m1(div_m1),
    .len_code(len_code), .two_stop(two_stop), .par_en(par_en),
    .par_even(par_even), .par_stick(par_stick), .brk(brk),
    .loop_en(loop_en), .cts_flow(cts_flow), .cts(cts),
    .txd(txd), .loop_txd(loop_txd), .buf_count(buf_count),
    .tx_empty(tx_empty)
  );

  // behavioural reference model
  logic [7:0] m_q[$];
  bit         m_bits[$];
  bit         m_busy;
  int         m_sub, m_bcnt;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_q.delete(); m_bits.delete();
      m_busy = 0; m_sub = 0; m_bcnt = 0;
    end else begin
      bit tk, st, full_pre;
      tk = (m_bcnt >= int'(div_m1));
      full_pre = (m_q.size() == DEPTH);
      st = !m_busy && m_q.size() != 0 && tx_enable && (!cts_flow || cts) && !flush;
      if (m_busy) begin
        if (tk) begin
          if (m_sub == 15) begin
            m_sub = 0;
            void'(m_bits.pop_front());
            if (m_bits.size() == 0) m_busy = 0;
          end else m_sub++;
        end
      end else if (st) begin
        logic [7:0] b;
        int n, ones;
        bit p;
        b = m_q.pop_front();
        n = int'(len_code) + 5;
        ones = 0;
        m_bits.push_back(1'b0);
        for (int i = 0; i < n; i++) begin
          m_bits.push_back(b[i]);
          ones += int'(b[i]);
        end
        if (par_en) begin
          if (par_stick) p = !par_even;
          else if (par_even) p = (ones % 2 == 1);
          else p = (ones % 2 == 0);
          m_bits.push_back(p);
        end
        m_bits.push_back(1'b1);
        if (two_stop) m_bits.push_back(1'b1);
        m_busy = 1; m_sub = 0;
      end
      if (flush) m_q.delete();
      else if (wr_en && !full_pre) m_q.push_back(wr_data);
      m_bcnt = tk ? 0 : m_bcnt + 1;
    end
  end

  // per-cycle comparison, away from the clock edge and after input changes
  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      bit line, raw, e_txd, e_loop, e_emp;
      int e_cnt;
      line   = m_busy ? m_bits[0] : 1'b1;
      raw    = brk ? 1'b0 : line;
      e_txd  = loop_en ? 1'b1 : raw;
      e_loop = loop_en ? raw : 1'b1;
      e_cnt  = m_q.size();
      e_emp  = (e_cnt == 0) && !m_busy;
      checks++;
      if (txd !== e_txd || loop_txd !== e_loop || tx_empty !== e_emp ||
          int'(buf_count) != e_cnt) begin
        fails++;
        $display("FAIL %s t=%0t: txd=%b/%b loop_txd=%b/%b empty=%b/%b count=%0d/%0d (actual/expected)",
                 tag, $time, txd, e_txd, loop_txd, e_loop, tx_empty, e_emp, buf_count, e_cnt);
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] b);
    wr_en = 1'b1; wr_data = b;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drain();
    int guard = 0;
    while ((m_q.size() != 0 || m_busy) && guard < 20000) begin
      @(negedge clk); guard++;
    end
    step(3);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      fails++;
      $display("FAIL watchdog: actual=%0d expected<190000 cycles", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 0; wr_data = 0; tx_enable = 1; flush = 0;
    div_m1 = 0; len_code = 2'd3; two_stop = 0; par_en = 0; par_even = 0;
    par_stick = 0; brk = 0; loop_en = 0; cts_flow = 0; cts = 0;
    step(5);
    rst_n = 1'b1;
    step(2);
    #2;
    check(txd === 1'b1, "R13 reset line", int'(txd), 1);
    check(tx_empty === 1'b1, "R11 reset empty", int'(tx_empty), 1);
    check(buf_count == 0, "R10 reset count", int'(buf_count), 0);
    @(negedge clk);

    tag = "R2"; push(8'hA5); drain(); push(8'h01); drain();
    tag = "R3";
    len_code = 2'd0; push(8'hE3); drain();
    len_code = 2'd1; push(8'hD6); drain();
    len_code = 2'd2; push(8'hFF); drain();
    len_code = 2'd3;
    tag = "R4"; two_stop = 1; push(8'h3C); drain(); two_stop = 0;
    tag = "R5";
    par_en = 1;
    par_even = 1; push(8'h07); drain();
    par_even = 0; push(8'h07); drain();
    par_stick = 1; par_even = 0; push(8'h00); drain();
    par_even = 1; push(8'hFF); drain();
    par_stick = 0; par_en = 0;
    tag = "R1";
    div_m1 = 8'd2; push(8'h5A); drain();
    div_m1 = 8'd5; push(8'h81); drain();
    div_m1 = 8'd0;

    tag = "R10";
    tx_enable = 0;
    for (int i = 0; i < 6; i++) push(8'h10 + 8'(i));
    #2;
    check(buf_count == 3'd4, "R10 full count", int'(buf_count), 4);
    check(tx_empty === 1'b0, "R11 not empty", int'(tx_empty), 0);
    @(negedge clk);
    tag = "R8"; step(50); tx_enable = 1; step(40); tx_enable = 0; step(400);
    tx_enable = 1; drain();

    tag = "R7";
    cts_flow = 1; cts = 0; push(8'hC3); push(8'h3C); step(40);
    cts = 1; step(30); cts = 0; step(300);
    #2;
    check(buf_count == 3'd1, "R7 held byte", int'(buf_count), 1);
    @(negedge clk);
    cts = 1; drain(); cts_flow = 0;

    tag = "R9";
    push(8'h96); push(8'h11); push(8'h22); step(20);
    flush = 1; wr_en = 1; wr_data = 8'h77;
    @(negedge clk);
    flush = 0; wr_en = 0;
    #2;
    check(buf_count == 3'd0, "R9 flushed", int'(buf_count), 0);
    @(negedge clk);
    drain();

    tag = "R6"; push(8'h55); step(50); brk = 1; step(100); brk = 0; drain();
    brk = 1; step(20); brk = 0; step(2);
    tag = "R12"; loop_en = 1; push(8'h6B); step(60); brk = 1; step(10); brk = 0;
    drain(); loop_en = 0;
    tag = "R13"; push(8'h9E); push(8'h2D); step(10);
    len_code = 2'd1; par_en = 1; two_stop = 1; drain();
    len_code = 2'd3; par_en = 0; two_stop = 0;
    tag = "R11"; step(5);
    #2;
    check(tx_empty === 1'b1, "R11 drained", int'(tx_empty), 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule